// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a host memory port and up to four low-power SRAM banks. The host drives one active-low chip enable and a two-bit bank select. The block turns these into four active-low bank enables, and at most one of them is low at a time. An external voltage comparator supplies a power-fail flag that is already synchronous to the block clock.

While power is good, the block decodes the chip enable into the selected bank, one clock after the inputs change. When power fails, every bank is write-protected. An access that is already driving a bank may run on until the host releases the chip enable. If the host does not release it within a bounded number of cycles, the bank is forced off anyway.

After power returns, all banks stay disabled for a programmable recovery period so that the host can stabilise. A status output reports whenever the banks are protected. Both the timeout and the recovery period are parameters counted in clock cycles.

Top module: `pf_ce_conditioner`

## Requirements
- R1: When `ce_n` is sampled high, all four bits of `bank_ce_n` are high after the next clock edge, whatever `sel` is.
- R2: With power good and `ce_n` sampled low, the next clock edge drives exactly one bit low. `sel`=0 gives bit 0, 1 gives bit 1, 2 gives bit 2, and 3 gives bit 3. For example, `sel`=2 gives `bank_ce_n`=4'b1011.
- R3: When `pwr_fail` is sampled high and no bank is active, `bank_ce_n` is 4'b1111 after that edge, and it stays 4'b1111 while `pwr_fail` stays high, whatever `ce_n` does.
- R4: When `pwr_fail` is sampled high while a bank is active and `ce_n` is still low, the same bank stays low, even if `sel` changes. The first edge that samples `ce_n` high drives all enables high.
- R5: An in-flight access that is never released is forced off. `bank_ce_n` becomes 4'b1111 on the (WPT_CYCLES+1)-th edge, counting the edge that sampled `pwr_fail` as the first, and it is still active on the WPT_CYCLES-th edge.
- R6: After `pwr_fail` is sampled low in the protected state, `wprot` and `bank_ce_n`=4'b1111 hold for RECOVER_CYCLES+1 edges, counting that edge as the first. Decoding resumes on the edge after that.
- R7: An access that begins while `pwr_fail` is high, or during the recovery period, never drives any bank low.
- R8: During reset, and right after it, `bank_ce_n` is 4'b1111 and `wprot` is high. `wprot` falls on the RECOVER_CYCLES-th edge after `rst_n` is released.
- R9: `wprot` goes high on the same edge that first reacts to `pwr_fail`. It stays high in every state other than normal decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| sel | input | 2 | Bank select |
| pwr_fail | input | 1 | Synchronous power-fail flag from the comparator, active high |
| bank_ce_n | output | 4 | Conditioned bank enables, active low |
| wprot | output | 1 | High while the banks are write-protected |

## Verification
The bank decoder gives no external sign of its state, so a wrong state shows up only in how the enables and `wprot` behave. A state that leaves normal decoding too early or too late shows on the enables within one clock. A miscounted timeout or recovery shifts the edge on which `bank_ce_n` returns high, or on which `wprot` falls, by a whole number of cycles, so the bench counts edges exactly. A drain that fails to hold shows at once as a changed or dropped bank while `ce_n` is still low.

// File: rtl/pf_ce_conditioner.sv
module pf_ce_conditioner #(
  parameter int WPT_CYCLES     = 8,
  parameter int RECOVER_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic [1:0] sel,
  input  logic       pwr_fail,
  output logic [3:0] bank_ce_n,
  output logic       wprot
);

  localparam int MAXC  = (WPT_CYCLES > RECOVER_CYCLES) ? WPT_CYCLES : RECOVER_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WPT_LOAD = CNT_W'(WPT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOVER_CYCLES - 1);

  typedef enum logic [1:0] {ST_NORMAL, ST_DRAIN, ST_PROTECT, ST_RECOVER} st_t;

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [3:0]       out_n;
  logic [3:0]       dec;
  logic             live;

  assign dec   = ce_n ? 4'hF : ~(4'b0001 << sel);
  assign live  = ~&bank_ce_n;
  assign wprot = (st != ST_NORMAL);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    out_n = 4'hF;
    case (st)
      ST_NORMAL: begin
        if (!pwr_fail) begin
          out_n = dec;
        end else if (!ce_n && live) begin
          st_n  = ST_DRAIN;
          cnt_n = WPT_LOAD;
          out_n = bank_ce_n;
        end else begin
          st_n = ST_PROTECT;
        end
      end
      ST_DRAIN: begin
        if (ce_n || cnt == '0) begin
          st_n = ST_PROTECT;
        end else begin
          cnt_n = cnt - 1'b1;
          out_n = bank_ce_n;
        end
      end
      ST_PROTECT: begin
        if (!pwr_fail) begin
          st_n  = ST_RECOVER;
          cnt_n = REC_LOAD;
        end
      end
      default: begin
        if (pwr_fail)        st_n = ST_PROTECT;
        else if (cnt == '0)  st_n = ST_NORMAL;
        else                 cnt_n = cnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RECOVER;
      cnt       <= REC_LOAD;
      bank_ce_n <= 4'hF;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      bank_ce_n <= out_n;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (bank_ce_n == 4'hF));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_ce_n));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROTECT) |-> (bank_ce_n == 4'hF));

  assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && !ce_n && cnt != '0) |=> $stable(bank_ce_n));

  assert_no_new_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wprot && bank_ce_n == 4'hF) |=> (bank_ce_n == 4'hF));

  assert_wprot_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> wprot);

endmodule

// File: tb/test_pf_ce_conditioner.sv
`timescale 1ns/1ps
module test_pf_ce_conditioner;
  localparam int WPT = 8;
  localparam int REC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       pwr_fail = 1'b0;
  logic [3:0] bank_ce_n;
  logic       wprot;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pf_ce_conditioner #(.WPT_CYCLES(WPT), .RECOVER_CYCLES(REC)) i_pf_ce_conditioner (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel(sel), .pwr_fail(pwr_fail),
    .bank_ce_n(bank_ce_n), .wprot(wprot)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic edges_until_unprot(output int n);
    n = 0;
    while (wprot && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    check("R8 bank in reset", bank_ce_n, 4'hF);
    check("R8 wprot in reset", wprot, 1);
    rst_n = 1'b1;
    edges_until_unprot(n);
    check("R8 reset recovery edges", n, REC);
    check("R8 bank after recovery", bank_ce_n, 4'hF);
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      ce_n = 1'b0; sel = 2'(s);
      step();
      check("R2 decode", bank_ce_n, 4'hF & ~(4'b0001 << s));
    end
    ce_n = 1'b1; sel = 2'd2;
    step();
    check("R1 idle sel2", bank_ce_n, 4'hF);
    sel = 2'd1;
    step();
    check("R1 idle sel1", bank_ce_n, 4'hF);
    check("R9 wprot low in normal", wprot, 0);
  endtask

  task automatic recover_and_check();
    int n;
    ce_n = 1'b0; sel = 2'd3;
    pwr_fail = 1'b0;
    n = 0;
    while (wprot && n < 1000) begin
      step();
      n++;
      if (bank_ce_n != 4'hF) check("R7 access in recovery", bank_ce_n, 4'hF);
    end
    check("R6 recovery edges", n, REC + 1);
    check("R6 bank at end of recovery", bank_ce_n, 4'hF);
    step();
    check("R6 decode resumes", bank_ce_n, 4'b0111);
    ce_n = 1'b1;
    step();
  endtask

  task automatic t_fail_idle();
    ce_n = 1'b1;
    pwr_fail = 1'b1;
    step();
    check("R9 wprot on fail", wprot, 1);
    check("R3 bank locked", bank_ce_n, 4'hF);
    ce_n = 1'b0; sel = 2'd0;
    step();
    check("R7 new access during fail", bank_ce_n, 4'hF);
    sel = 2'd2;
    step();
    check("R3 ignores ce", bank_ce_n, 4'hF);
    recover_and_check();
  endtask

  task automatic t_drain();
    ce_n = 1'b0; sel = 2'd1;
    step();
    check("R2 before drain", bank_ce_n, 4'b1101);
    pwr_fail = 1'b1;
    step();
    check("R4 held at fail", bank_ce_n, 4'b1101);
    check("R9 wprot in drain", wprot, 1);
    sel = 2'd3;
    step();
    check("R4 sel change ignored", bank_ce_n, 4'b1101);
    ce_n = 1'b1;
    step();
    check("R4 locked on release", bank_ce_n, 4'hF);
    ce_n = 1'b0;
    step();
    check("R7 no re-entry", bank_ce_n, 4'hF);
    recover_and_check();
  endtask

  task automatic t_timeout();
    int k;
    ce_n = 1'b0; sel = 2'd2;
    step();
    check("R2 before timeout", bank_ce_n, 4'b1011);
    pwr_fail = 1'b1;
    k = 0;
    while (bank_ce_n != 4'hF && k < 1000) begin
      step();
      k++;
      if (k == WPT) check("R5 active at WPT", bank_ce_n, 4'b1011);
    end
    check("R5 forced off edge", k, WPT + 1);
    step();
    check("R5 stays locked", bank_ce_n, 4'hF);
    recover_and_check();
  endtask

  initial begin
    t_reset();
    t_decode();
    t_fail_idle();
    t_drain();
    t_timeout();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule